// File: doc/BRIEF.md
# Ethernet Frame Check Sequence Strip and Regenerate Adapter

This block sits between an Ethernet MAC and a serial encapsulation path and handles the 4-byte CRC-32 frame check sequence (FCS) in both directions. In the Ethernet-to-serial direction it can drop the trailing FCS of every frame. In the serial-to-Ethernet direction it can compute a fresh FCS and append it after the last payload byte. Every side is a byte-wide stream with valid, last and ready.

One mode input, `keep_fcs_i`, selects the behaviour of both directions together. At 0, the reset default, the block strips and regenerates the FCS. At 1, both directions pass frames through unchanged. Each direction samples the mode on the first byte of a frame and keeps it until that frame ends.

Both directions enforce a frame length limit on the Ethernet side of 2016 bytes, FCS included. A frame that would exceed the limit is cut short, its remaining input bytes are dropped, and a one-cycle error pulse is raised.

Top module: `crc_frame_adapter`

## Requirements
- R1: After reset, `ser_tx_valid_o`, `eth_tx_valid_o`, `strip_err_o` and `append_err_o` are all low, and the mode takes effect as 0 (strip and regenerate).
- R2: In mode 0, a frame of n ≥ 5 bytes on the `eth_rx` input leaves `ser_tx` as its first n−4 bytes, in order. Last is set on byte n−4. A byte is released only after four later bytes of the same frame have arrived.
- R3: In mode 0, a frame of 1 to 4 bytes on `eth_rx` produces no output bytes, and the frame that follows is handled normally.
- R4: In mode 0, a frame of n bytes on `ser_rx` leaves `eth_tx` as the same n bytes followed by 4 FCS bytes, with last only on the final FCS byte. The FCS is CRC-32 with polynomial 0x04C11DB7, reflected input and output, initial value 0xFFFFFFFF and final XOR 0xFFFFFFFF, sent least-significant byte first. For the ASCII input "123456789" the FCS bytes are 26 39 F4 CB. `ser_rx_ready_o` stays low while the FCS bytes are sent.
- R5: In mode 1, frames on `eth_rx` appear on `ser_tx` unchanged, with the same bytes and the same last position.
- R6: In mode 1, frames on `ser_rx` appear on `eth_tx` unchanged, with no bytes appended.
- R7: Ethernet-to-serial length limit. An input frame of up to 2016 bytes raises no error. If the frame has more bytes, input byte 2016 ends the output frame: that is 2012 output bytes in mode 0 and 2016 in mode 1. Further input bytes up to and including the input last are accepted and dropped. `strip_err_o` pulses for one cycle, in the cycle after byte 2016 is accepted.
- R8: Serial-to-Ethernet length limit. The output frame, FCS included, never exceeds 2016 bytes. In mode 0 the payload is cut at 2012 bytes and the FCS covers those bytes; in mode 1 the frame is cut at 2016 bytes. Further input bytes up to the input last are dropped. `append_err_o` pulses for one cycle, in the cycle after the cut byte is accepted.
- R9: A change of `keep_fcs_i` after a frame's first byte has been accepted has no effect on that frame. The next frame uses the new value.
- R10: Under any pattern of ready deassertion, no byte is lost, duplicated or reordered. An FCS byte that is offered but not taken stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| keep_fcs_i | input | 1 | 0: strip and regenerate the FCS; 1: pass frames through unchanged |
| eth_rx_data_i | input | 8 | Byte received from the MAC |
| eth_rx_valid_i | input | 1 | `eth_rx_data_i` is valid |
| eth_rx_last_i | input | 1 | Final byte of the received frame |
| eth_rx_ready_o | output | 1 | Block accepts an `eth_rx` byte |
| ser_tx_data_o | output | 8 | Byte toward the serial path |
| ser_tx_valid_o | output | 1 | `ser_tx_data_o` is valid |
| ser_tx_last_o | output | 1 | Final byte of the frame toward the serial path |
| ser_tx_ready_i | input | 1 | Serial path accepts a byte |
| ser_rx_data_i | input | 8 | Byte from the serial path |
| ser_rx_valid_i | input | 1 | `ser_rx_data_i` is valid |
| ser_rx_last_i | input | 1 | Final byte of the frame from the serial path |
| ser_rx_ready_o | output | 1 | Block accepts a `ser_rx` byte |
| eth_tx_data_o | output | 8 | Byte toward the MAC |
| eth_tx_valid_o | output | 1 | `eth_tx_data_o` is valid |
| eth_tx_last_o | output | 1 | Final byte of the frame toward the MAC |
| eth_tx_ready_i | input | 1 | MAC accepts a byte |
| strip_err_o | output | 1 | One-cycle pulse when an Ethernet-to-serial frame is truncated |
| append_err_o | output | 1 | One-cycle pulse when a serial-to-Ethernet frame is truncated |

## Verification
Data outputs are combinational from the inputs and the held state, so a byte is due in the same cycle as the handshake that releases it. In strip mode that handshake is the one for the byte four positions later in the frame. The FCS bytes follow the payload's last handshake on the next four accepted output cycles. An error pulse is due exactly one cycle after the offending byte is accepted. The bench drives inputs just after a rising edge and samples transfers and pulses at the falling edge, recording each output byte in the cycle in which its handshake completes. It compares whole frames and pulse counts once the output frame has closed or a quiet interval has passed, and the checker module pins each error pulse to the preceding cycle's transfer.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned FCS_LEN = 4;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;  // 0x04C11DB7 bit-reversed
  localparam logic [31:0] CRC_INIT      = 32'hFFFFFFFF;

  // one byte through the reflected CRC-32, lsb first
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [BYTE_W-1:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/fcs_len_guard.sv
module fcs_len_guard #(
  parameter int unsigned CW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          clr_i,
  input  logic [CW-1:0] limit_i,
  output logic          at_max_o
);
  logic [CW-1:0] cnt_q;

  assign at_max_o = (cnt_q == limit_i - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/fcs_strip.sv
module fcs_strip
  import fcs_pkg::*;
#(
  parameter int unsigned MAX_LEN = 2016,
  localparam int unsigned CW = $clog2(MAX_LEN + 1),
  localparam int unsigned FW = $clog2(FCS_LEN + 1),
  localparam int unsigned IW = $clog2(FCS_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              keep_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_valid_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic [BYTE_W-1:0] out_data_o,
  output logic              out_valid_o,
  output logic              out_last_o,
  input  logic              out_ready_i,
  output logic              err_o
);
  logic [BYTE_W-1:0] hold_q [FCS_LEN];
  logic [FW-1:0]     fill_q;
  logic in_frame_q, mode_q, drop_q, err_q;
  logic mode_eff, eff_last, full, acc, step, fin, at_max;

  fcs_len_guard #(.CW(CW)) u_guard (
    .clk_i, .rst_ni,
    .step_i  (step),
    .clr_i   (fin),
    .limit_i (CW'(MAX_LEN)),
    .at_max_o(at_max)
  );

  always_comb begin
    mode_eff    = in_frame_q ? mode_q : keep_i;
    eff_last    = in_last_i | at_max;
    full        = (fill_q == FW'(FCS_LEN));
    out_data_o  = in_data_i;
    out_valid_o = 1'b0;
    out_last_o  = 1'b0;
    in_ready_o  = 1'b0;
    if (drop_q) begin
      in_ready_o = 1'b1;
    end else if (mode_eff) begin
      out_valid_o = in_valid_i;
      out_last_o  = eff_last;
      in_ready_o  = out_ready_i;
    end else begin
      // oldest held byte leaves as the fifth arrives
      out_data_o  = hold_q[0];
      out_valid_o = in_valid_i & full;
      out_last_o  = eff_last;
      in_ready_o  = full ? out_ready_i : 1'b1;
    end
    acc  = in_valid_i & in_ready_o;
    step = acc & ~drop_q;
    fin  = step & eff_last;
  end

  assign err_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      mode_q     <= 1'b0;
      drop_q     <= 1'b0;
      err_q      <= 1'b0;
      fill_q     <= '0;
      for (int i = 0; i < FCS_LEN; i++) hold_q[i] <= '0;
    end else begin
      err_q <= step & at_max & ~in_last_i;
      if (drop_q && acc && in_last_i) drop_q <= 1'b0;
      if (step) begin
        if (!in_frame_q) mode_q <= keep_i;
        in_frame_q <= 1'b1;
        if (!mode_eff) begin
          if (eff_last) begin
            fill_q <= '0;
          end else if (full) begin
            for (int i = 0; i < FCS_LEN - 1; i++) hold_q[i] <= hold_q[i+1];
            hold_q[FCS_LEN-1] <= in_data_i;
          end else begin
            hold_q[fill_q[IW-1:0]] <= in_data_i;
            fill_q <= fill_q + FW'(1);
          end
        end
        if (fin) begin
          in_frame_q <= 1'b0;
          if (at_max && !in_last_i) drop_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fcs_append.sv
module fcs_append
  import fcs_pkg::*;
#(
  parameter int unsigned MAX_LEN = 2016,
  localparam int unsigned CW = $clog2(MAX_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              keep_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_valid_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic [BYTE_W-1:0] out_data_o,
  output logic              out_valid_o,
  output logic              out_last_o,
  input  logic              out_ready_i,
  output logic              err_o
);
  logic        in_frame_q, mode_q, drop_q, ins_q, err_q;
  logic [1:0]  idx_q;
  logic [31:0] crc_q, crc_nxt, fcs;
  logic [CW-1:0] limit;
  logic mode_eff, eff_last, acc, step, fin, at_max;

  fcs_len_guard #(.CW(CW)) u_guard (
    .clk_i, .rst_ni,
    .step_i  (step),
    .clr_i   (fin),
    .limit_i (limit),
    .at_max_o(at_max)
  );

  always_comb begin
    mode_eff    = in_frame_q ? mode_q : keep_i;
    limit       = mode_eff ? CW'(MAX_LEN) : CW'(MAX_LEN - FCS_LEN);
    eff_last    = in_last_i | at_max;
    crc_nxt     = crc_step(in_frame_q ? crc_q : CRC_INIT, in_data_i);
    fcs         = ~crc_q;
    out_data_o  = in_data_i;
    out_valid_o = 1'b0;
    out_last_o  = 1'b0;
    in_ready_o  = 1'b0;
    if (ins_q) begin
      out_data_o  = fcs[{idx_q, 3'b000} +: BYTE_W];
      out_valid_o = 1'b1;
      out_last_o  = (idx_q == 2'd3);
    end else if (drop_q) begin
      in_ready_o = 1'b1;
    end else begin
      out_valid_o = in_valid_i;
      out_last_o  = mode_eff & eff_last;
      in_ready_o  = out_ready_i;
    end
    acc  = in_valid_i & in_ready_o;
    step = acc & ~drop_q & ~ins_q;
    fin  = step & eff_last;
  end

  assign err_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      mode_q     <= 1'b0;
      drop_q     <= 1'b0;
      ins_q      <= 1'b0;
      err_q      <= 1'b0;
      idx_q      <= '0;
      crc_q      <= CRC_INIT;
    end else begin
      err_q <= step & at_max & ~in_last_i;
      if (ins_q && out_ready_i) begin
        idx_q <= idx_q + 2'd1;
        if (idx_q == 2'd3) ins_q <= 1'b0;
      end
      if (!ins_q && drop_q && acc && in_last_i) drop_q <= 1'b0;
      if (step) begin
        if (!in_frame_q) mode_q <= keep_i;
        in_frame_q <= 1'b1;
        crc_q      <= crc_nxt;
        if (fin) begin
          in_frame_q <= 1'b0;
          if (!mode_eff) begin
            ins_q <= 1'b1;
            idx_q <= '0;
          end
          if (at_max && !in_last_i) drop_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/crc_frame_adapter.sv
module crc_frame_adapter
  import fcs_pkg::*;
#(
  parameter int unsigned MAX_LEN = 2016
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              keep_fcs_i,
  input  logic [BYTE_W-1:0] eth_rx_data_i,
  input  logic              eth_rx_valid_i,
  input  logic              eth_rx_last_i,
  output logic              eth_rx_ready_o,
  output logic [BYTE_W-1:0] ser_tx_data_o,
  output logic              ser_tx_valid_o,
  output logic              ser_tx_last_o,
  input  logic              ser_tx_ready_i,
  input  logic [BYTE_W-1:0] ser_rx_data_i,
  input  logic              ser_rx_valid_i,
  input  logic              ser_rx_last_i,
  output logic              ser_rx_ready_o,
  output logic [BYTE_W-1:0] eth_tx_data_o,
  output logic              eth_tx_valid_o,
  output logic              eth_tx_last_o,
  input  logic              eth_tx_ready_i,
  output logic              strip_err_o,
  output logic              append_err_o
);
  fcs_strip #(.MAX_LEN(MAX_LEN)) u_strip (
    .clk_i, .rst_ni,
    .keep_i     (keep_fcs_i),
    .in_data_i  (eth_rx_data_i),
    .in_valid_i (eth_rx_valid_i),
    .in_last_i  (eth_rx_last_i),
    .in_ready_o (eth_rx_ready_o),
    .out_data_o (ser_tx_data_o),
    .out_valid_o(ser_tx_valid_o),
    .out_last_o (ser_tx_last_o),
    .out_ready_i(ser_tx_ready_i),
    .err_o      (strip_err_o)
  );

  fcs_append #(.MAX_LEN(MAX_LEN)) u_app (
    .clk_i, .rst_ni,
    .keep_i     (keep_fcs_i),
    .in_data_i  (ser_rx_data_i),
    .in_valid_i (ser_rx_valid_i),
    .in_last_i  (ser_rx_last_i),
    .in_ready_o (ser_rx_ready_o),
    .out_data_o (eth_tx_data_o),
    .out_valid_o(eth_tx_valid_o),
    .out_last_o (eth_tx_last_o),
    .out_ready_i(eth_tx_ready_i),
    .err_o      (append_err_o)
  );
endmodule

// File: rtl/fcs_adapter_chk.sv
module fcs_adapter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ser_tx_valid_o,
  input logic       ser_tx_last_o,
  input logic       ser_tx_ready_i,
  input logic       ser_rx_valid_i,
  input logic       ser_rx_ready_o,
  input logic [7:0] eth_tx_data_o,
  input logic       eth_tx_valid_o,
  input logic       eth_tx_ready_i,
  input logic       strip_err_o,
  input logic       append_err_o
);
  // output valid without input valid means FCS insertion
  assert_fcs_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eth_tx_valid_o && !ser_rx_valid_i && !eth_tx_ready_i |=> eth_tx_valid_o && $stable(eth_tx_data_o));

  assert_fcs_stall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eth_tx_valid_o && !ser_rx_valid_i |-> !ser_rx_ready_o);

  assert_strip_err_at_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strip_err_o |-> $past(ser_tx_valid_o && ser_tx_ready_i && ser_tx_last_o));

  assert_strip_err_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strip_err_o |=> !strip_err_o);

  assert_append_err_xfer_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    append_err_o |-> $past(eth_tx_valid_o && eth_tx_ready_i));

  assert_append_err_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    append_err_o |=> !append_err_o);
endmodule

bind crc_frame_adapter fcs_adapter_chk u_chk (.*);

// File: tb/tb_crc_frame_adapter.sv
`timescale 1ns/1ps
module tb_crc_frame_adapter;
  typedef logic [7:0] byte_q_t[$];

  logic clk = 1'b0, rst_n = 1'b0, keep = 1'b0;
  logic [7:0] eth_rx_data = '0, ser_rx_data = '0;
  logic eth_rx_valid = 1'b0, eth_rx_last = 1'b0, ser_rx_valid = 1'b0, ser_rx_last = 1'b0;
  logic ser_tx_ready = 1'b1, eth_tx_ready = 1'b1;
  logic eth_rx_ready, ser_tx_valid, ser_tx_last, ser_rx_ready, eth_tx_valid, eth_tx_last;
  logic strip_err, append_err;
  logic [7:0] ser_tx_data, eth_tx_data;

  int total = 0, bad = 0, cyc = 0;
  int frames_s = 0, frames_e = 0, errs_s = 0, errs_e = 0;
  bit bp = 1'b0;
  byte_q_t got_s, got_e;

  always #4 clk = ~clk;

  crc_frame_adapter dut (
    .clk_i(clk), .rst_ni(rst_n), .keep_fcs_i(keep),
    .eth_rx_data_i(eth_rx_data), .eth_rx_valid_i(eth_rx_valid), .eth_rx_last_i(eth_rx_last),
    .eth_rx_ready_o(eth_rx_ready),
    .ser_tx_data_o(ser_tx_data), .ser_tx_valid_o(ser_tx_valid), .ser_tx_last_o(ser_tx_last),
    .ser_tx_ready_i(ser_tx_ready),
    .ser_rx_data_i(ser_rx_data), .ser_rx_valid_i(ser_rx_valid), .ser_rx_last_i(ser_rx_last),
    .ser_rx_ready_o(ser_rx_ready),
    .eth_tx_data_o(eth_tx_data), .eth_tx_valid_o(eth_tx_valid), .eth_tx_last_o(eth_tx_last),
    .eth_tx_ready_i(eth_tx_ready),
    .strip_err_o(strip_err), .append_err_o(append_err)
  );

  always @(posedge clk) begin
    #1;
    ser_tx_ready = bp ? (($urandom % 4) != 0) : 1'b1;
    eth_tx_ready = bp ? (($urandom % 4) != 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (ser_tx_valid && ser_tx_ready) begin
        got_s.push_back(ser_tx_data);
        if (ser_tx_last) frames_s++;
      end
      if (eth_tx_valid && eth_tx_ready) begin
        got_e.push_back(eth_tx_data);
        if (eth_tx_last) frames_e++;
      end
      if (strip_err) errs_s++;
      if (append_err) errs_e++;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input byte_q_t fr);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (fr[i]) begin
      for (int j = 0; j < 8; j++) begin
        logic fb = c[0] ^ fr[i][j];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  function automatic void exp_strip(input byte_q_t fr, input bit mode, output byte_q_t o);
    int n = (fr.size() > 2016) ? 2016 : fr.size();
    int k = mode ? n : n - 4;
    o = {};
    for (int i = 0; i < k; i++) o.push_back(fr[i]);
  endfunction

  function automatic void exp_app(input byte_q_t fr, input bit mode, output byte_q_t o);
    int lim = mode ? 2016 : 2012;
    int n = (fr.size() > lim) ? lim : fr.size();
    logic [31:0] c;
    o = {};
    for (int i = 0; i < n; i++) o.push_back(fr[i]);
    if (!mode) begin
      c = ref_crc(o);
      for (int b = 0; b < 4; b++) o.push_back(c[8*b +: 8]);
    end
  endfunction

  task automatic cmp(ref byte_q_t got, input byte_q_t exp, input string tag);
    int bad_at = -1;
    chk(got.size() == exp.size(), tag, "frame length", got.size(), exp.size());
    foreach (exp[i]) if (bad_at < 0 && i < got.size() && got[i] != exp[i]) bad_at = i;
    if (bad_at >= 0) chk(1'b0, tag, $sformatf("byte %0d", bad_at), got[bad_at], exp[bad_at]);
    else chk(1'b1, tag, "bytes", 0, 0);
    got = {};
  endtask

  task automatic send_eth(input byte_q_t fr, input int flip_at);
    for (int i = 0; i < fr.size(); i++) begin
      if (i == flip_at) keep = ~keep;
      eth_rx_data = fr[i]; eth_rx_last = (i == fr.size() - 1); eth_rx_valid = 1'b1;
      do @(negedge clk); while (!eth_rx_ready);
      @(posedge clk); #1;
    end
    eth_rx_valid = 1'b0; eth_rx_last = 1'b0;
  endtask

  task automatic send_ser(input byte_q_t fr, input int flip_at);
    for (int i = 0; i < fr.size(); i++) begin
      if (i == flip_at) keep = ~keep;
      ser_rx_data = fr[i]; ser_rx_last = (i == fr.size() - 1); ser_rx_valid = 1'b1;
      do @(negedge clk); while (!ser_rx_ready);
      @(posedge clk); #1;
    end
    ser_rx_valid = 1'b0; ser_rx_last = 1'b0;
  endtask

  task automatic run_eth(input byte_q_t fr, input bit mode, input int flip_at, input int exp_err, input string tag);
    byte_q_t e;
    int f0 = frames_s, e0 = errs_s;
    keep = mode;
    exp_strip(fr, mode, e);
    send_eth(fr, flip_at);
    if (e.size() > 0) for (int k = 0; k < 5000 && frames_s == f0; k++) @(posedge clk);
    repeat (20) @(posedge clk);
    #1;
    cmp(got_s, e, tag);
    chk(errs_s - e0 == exp_err, tag, "strip_err pulses", errs_s - e0, exp_err);
    keep = mode;
  endtask

  task automatic run_ser(input byte_q_t fr, input bit mode, input int flip_at, input int exp_err, input string tag);
    byte_q_t e;
    int f0 = frames_e, e0 = errs_e;
    keep = mode;
    exp_app(fr, mode, e);
    send_ser(fr, flip_at);
    for (int k = 0; k < 5000 && frames_e == f0; k++) @(posedge clk);
    repeat (20) @(posedge clk);
    #1;
    cmp(got_e, e, tag);
    chk(errs_e - e0 == exp_err, tag, "append_err pulses", errs_e - e0, exp_err);
    keep = mode;
  endtask

  function automatic byte_q_t mk(input int n);
    byte_q_t q;
    for (int i = 0; i < n; i++) q.push_back(8'($urandom));
    return q;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    byte_q_t fr, e;
    void'($urandom(32'd20161));
    repeat (3) @(posedge clk);
    #1;
    chk(!ser_tx_valid && !eth_tx_valid, "R1", "valids in reset", {ser_tx_valid, eth_tx_valid}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!ser_tx_valid && !eth_tx_valid && !strip_err && !append_err, "R1", "outputs after reset",
        {ser_tx_valid, eth_tx_valid, strip_err, append_err}, 0);

    // R4 known vector: FCS of "123456789" is 0xCBF43926, sent 26 39 F4 CB
    fr = {8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    e = fr;
    e.push_back(8'h26); e.push_back(8'h39); e.push_back(8'hF4); e.push_back(8'hCB);
    keep = 1'b0;
    send_ser(fr, -1);
    repeat (20) @(posedge clk);
    #1;
    cmp(got_e, e, "R4");

    run_eth(mk(12), 1'b0, -1, 0, "R2");
    run_eth(mk(5), 1'b0, -1, 0, "R2");
    for (int n = 1; n <= 4; n++) run_eth(mk(n), 1'b0, -1, 0, "R3");
    run_eth(mk(9), 1'b0, -1, 0, "R3");
    run_ser(mk(1), 1'b0, -1, 0, "R4");
    run_eth(mk(20), 1'b1, -1, 0, "R5");
    run_ser(mk(20), 1'b1, -1, 0, "R6");
    run_eth(mk(16), 1'b0, 3, 0, "R9");
    run_eth(mk(16), 1'b1, 3, 0, "R9");
    run_ser(mk(16), 1'b0, 3, 0, "R9");
    run_ser(mk(16), 1'b1, 3, 0, "R9");

    run_eth(mk(2016), 1'b1, -1, 0, "R7");
    run_eth(mk(2020), 1'b0, -1, 1, "R7");
    run_eth(mk(2017), 1'b1, -1, 1, "R7");
    run_ser(mk(2012), 1'b0, -1, 0, "R8");
    run_ser(mk(2015), 1'b0, -1, 1, "R8");
    run_ser(mk(2018), 1'b1, -1, 1, "R8");

    bp = 1'b1;
    for (int i = 0; i < 30; i++) begin
      run_eth(mk(1 + ($urandom % 64)), 1'($urandom % 2), -1, 0, "R10");
      run_ser(mk(1 + ($urandom % 64)), 1'($urandom % 2), -1, 0, "R10");
    end
    run_ser(mk(2013), 1'b0, -1, 1, "R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule